// File: doc/BRIEF.md
# Gated Power-of-Two Clock Divider

This block derives a slower clock from a reference clock. The divide ratio is always a power of two. Software sets it with a 3-bit logarithmic factor in a byte-wide register. A separate enable bit turns the divided output on and off. The output rests low when it is off.

The block never cuts a high pulse short. Start and stop are timed so that every high pulse keeps its full width, and each takes effect within a bound counted in reference cycles that scales with the ratio. A status bit shows whether the output is really running, so software can see when a stop has completed.

The intended use has three steps: clear the enable, write a new factor, then set the enable again. A factor written while the output runs is stored and can be read back, but it takes effect only at the next start from the fully stopped state. Several copies can share one register space. Each copy answers only at its own base address, which is a fixed base plus its index times a stride of 0x100.

Top module: `pow2_clkdiv`

## Requirements
- R1: After reset the output is low and stays low. The factor register reads 0x00 and the enable register reads 0x00.
- R2: A factor f from 1 to 7 selects a divide ratio R = 2^(f-1), and f = 0 acts exactly like f = 1. For R of 2 or more, the output is high for R/2 reference cycles and then low for R/2 cycles. For R = 1, the output follows the reference clock while it runs.
- R3: After the write that sets the enable bit, the first high level of the output comes within 2 + 3*R reference cycles. The output only starts while the enable bit is set.
- R4: After the write that clears the enable bit, the status bit reads 0 and the output is low within 3*R reference cycles. The output then stays low. The output only stops while the enable bit is clear, and it is low whenever it is not running.
- R5: Bit 0 of the enable register is a read-only status bit. It reads 1 while the output runs and 0 once the output has fully stopped. Writes to it have no effect.
- R6: The factor lives in bits [2:0] at offset 0x43 from the instance base. The enable is bit 7 at offset 0x46. The instance base is BASE_ADDR + INST_IDX*0x100. Writes to any other address change nothing, and reads from any other address return 0x00.
- R7: Unused register bits read as zero and ignore writes. This covers bits [7:3] of the factor register and bits [6:1] of the enable register.
- R8: A factor written while the output is enabled reads back at once. The running ratio does not change until the next start from the stopped state.
- R9: Every high pulse of a divided output (R of 2 or more) lasts exactly R/2 reference cycles. This includes the last pulse before a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Register address |
| regWrEn | input | 1 | Write strobe; the write is taken on the rising edge |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Read data for regAddr, combinational |
| divClk | output | 1 | Gated divided clock |

## Verification
Register writes take effect on the rising edge that samples regWrEn. Readback is combinational and is valid in the same cycle. Starting with a ratio of 2 or more puts the output high one edge after the enabling write. With a ratio of one, the first high phase of the reference clock is passed one edge later, because the gate is captured on the falling edge. The bench drives inputs on falling edges and samples a quarter period after each rising edge. It counts edges from the write until the first high sample and checks that count against 2 + 3*R. Counting from that first sample, it expects high exactly when the sample index modulo R is below R/2. For a stop, it counts edges until the status bit drops, checks that count against 3*R, and then watches for a low-only window of at least 2*R cycles.

// File: rtl/pow2_clkdiv_pkg.sv
package pow2_clkdiv_pkg;

  localparam int FACTOR_W = 3;
  localparam int MAX_LOG  = (1 << FACTOR_W) - 2;   // log2 of the largest ratio
  localparam int CNT_W    = MAX_LOG - 1;           // half-period counter width

  localparam int FACTOR_OFS = 'h43;
  localparam int ENABLE_OFS = 'h46;
  localparam int EN_BIT     = 7;
  localparam int STAT_BIT   = 0;

  typedef struct packed {
    logic                start;   // begin running on this edge
    logic                stop;    // stop running on this edge
    logic                run;     // output currently active
    logic [FACTOR_W-1:0] factor;  // factor in force (active or pending)
  } div_cmd_t;

  // factor 0 and 1 both mean divide by one
  function automatic int ratioLog(input logic [FACTOR_W-1:0] f);
    return (f == '0) ? 0 : int'(f) - 1;
  endfunction

endpackage

// File: rtl/pow2_clkdiv_ctrl.sv
module pow2_clkdiv_ctrl
  import pow2_clkdiv_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int BASE_ADDR = 0,
  parameter int INST_IDX  = 0,
  parameter int STRIDE    = 'h100
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWrEn,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  input  logic                phaseHigh,
  input  logic                wrapNow,
  output div_cmd_t            cmd,
  output logic                enQ,
  output logic                runQ,
  output logic [FACTOR_W-1:0] activeFactor
);

  localparam int INST_BASE = BASE_ADDR + INST_IDX * STRIDE;
  localparam logic [ADDR_W-1:0] FACTOR_ADDR = ADDR_W'(INST_BASE + FACTOR_OFS);
  localparam logic [ADDR_W-1:0] ENABLE_ADDR = ADDR_W'(INST_BASE + ENABLE_OFS);

  logic                hitFactor;
  logic                hitEnable;
  logic [FACTOR_W-1:0] factorQ;
  logic                ratioOne;
  logic                startReq;
  logic                stopReq;

  assign hitFactor = (regAddr == FACTOR_ADDR);
  assign hitEnable = (regAddr == ENABLE_ADDR);

  // programmed registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      factorQ <= '0;
      enQ     <= 1'b0;
    end else if (regWrEn) begin
      if (hitFactor) factorQ <= regWrData[FACTOR_W-1:0];
      if (hitEnable) enQ     <= regWrData[EN_BIT];
    end
  end

  // read mux, unused bits tied to zero
  always_comb begin
    regRdData = '0;
    if (hitFactor) begin
      regRdData[FACTOR_W-1:0] = factorQ;
    end else if (hitEnable) begin
      regRdData[EN_BIT]   = enQ;
      regRdData[STAT_BIT] = runQ;
    end
  end

  // start/stop decisions, stop only on a low-phase boundary
  assign ratioOne = (ratioLog(activeFactor) == 0);
  assign startReq = enQ & ~runQ;
  assign stopReq  = ~enQ & runQ & (ratioOne | ~phaseHigh | wrapNow);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ         <= 1'b0;
      activeFactor <= '0;
    end else if (startReq) begin
      runQ         <= 1'b1;
      activeFactor <= factorQ;
    end else if (stopReq) begin
      runQ <= 1'b0;
    end
  end

  always_comb begin
    cmd.start  = startReq;
    cmd.stop   = stopReq;
    cmd.run    = runQ;
    cmd.factor = runQ ? activeFactor : factorQ;
  end

endmodule

// File: rtl/pow2_clkdiv_datapath.sv
module pow2_clkdiv_datapath
  import pow2_clkdiv_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  div_cmd_t cmd,
  output logic     phaseQ,
  output logic     wrapNow,
  output logic     divClk
);

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] halfM1;
  logic             isOne;
  logic             passQ;
  int               lg;

  always_comb begin
    lg     = ratioLog(cmd.factor);
    isOne  = (lg == 0);
    halfM1 = isOne ? '0 : CNT_W'((1 << (lg - 1)) - 1);
  end

  assign wrapNow = (cntQ == halfM1);

  // half-period counter and phase for ratios of two and up
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ   <= '0;
      phaseQ <= 1'b0;
    end else if (cmd.stop) begin
      cntQ   <= '0;
      phaseQ <= 1'b0;
    end else if (cmd.start) begin
      cntQ   <= '0;
      phaseQ <= ~isOne;
    end else if (cmd.run && !isOne) begin
      if (wrapNow) begin
        cntQ   <= '0;
        phaseQ <= ~phaseQ;
      end else begin
        cntQ <= cntQ + 1'b1;
      end
    end
  end

  // divide-by-one gate, captured while the reference is low
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) passQ <= 1'b0;
    else       passQ <= cmd.run & isOne & ~cmd.stop;
  end

  assign divClk = isOne ? (clk & passQ) : phaseQ;

endmodule

// File: rtl/pow2_clkdiv.sv
module pow2_clkdiv
  import pow2_clkdiv_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int BASE_ADDR = 0,
  parameter int INST_IDX  = 0,
  parameter int STRIDE    = 'h100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              divClk
);

  div_cmd_t            cmd;
  logic                phaseQ;
  logic                wrapNow;
  logic                enQ;
  logic                runQ;
  logic [FACTOR_W-1:0] activeFactor;

  pow2_clkdiv_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR),
    .INST_IDX(INST_IDX), .STRIDE(STRIDE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData),
    .phaseHigh(phaseQ), .wrapNow(wrapNow),
    .cmd(cmd), .enQ(enQ), .runQ(runQ), .activeFactor(activeFactor)
  );

  pow2_clkdiv_datapath u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .phaseQ(phaseQ), .wrapNow(wrapNow), .divClk(divClk)
  );

endmodule

// File: rtl/pow2_clkdiv_checker.sv
module pow2_clkdiv_checker
  import pow2_clkdiv_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                enQ,
  input logic                runQ,
  input logic                phaseQ,
  input logic [FACTOR_W-1:0] activeFactor,
  input logic [DATA_W-1:0]   regRdData
);

  int ratio;
  int half;
  int stopCnt;
  int hiCnt;

  always_comb begin
    ratio = 1 << ratioLog(activeFactor);
    half  = ratio >> 1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stopCnt <= 0;
      hiCnt   <= 0;
    end else begin
      stopCnt <= (runQ && !enQ) ? stopCnt + 1 : 0;
      hiCnt   <= phaseQ ? hiCnt + 1 : 0;
    end
  end

  AST_START_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runQ) |-> $past(enQ));                                   // R3
  AST_STOP_NEEDS_DISABLE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(runQ) |-> !$past(enQ));                                  // R4
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !runQ |-> !phaseQ);                                            // R4
  AST_STOP_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    stopCnt <= 3 * ratio);                                         // R4
  AST_FACTOR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && $past(runQ)) |-> $stable(activeFactor));              // R8
  AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(phaseQ) |-> (hiCnt == half));                            // R9
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[6:3] == '0);                                         // R7

endmodule

bind pow2_clkdiv pow2_clkdiv_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .enQ(enQ), .runQ(runQ), .phaseQ(phaseQ),
  .activeFactor(activeFactor), .regRdData(regRdData)
);

// File: tb/pow2_clkdiv_test.sv
`timescale 1ns/1ps
module pow2_clkdiv_test;

  localparam int PERIOD = 10;
  localparam int QTR    = PERIOD / 4;
  localparam logic [15:0] FAC_A   = 16'h0143;   // instance 1
  localparam logic [15:0] EN_A    = 16'h0146;
  localparam logic [15:0] FOR_FAC = 16'h0043;   // instance 0 addresses
  localparam logic [15:0] FOR_EN  = 16'h0046;

  typedef struct packed {
    logic [7:0] factor;
    logic [7:0] ratio;
    logic [7:0] skew;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'd0, 8'd1,  8'd0},
    '{8'd1, 8'd1,  8'd3},
    '{8'd2, 8'd2,  8'd1},
    '{8'd3, 8'd4,  8'd2},
    '{8'd4, 8'd8,  8'd5},
    '{8'd5, 8'd16, 8'd7},
    '{8'd6, 8'd32, 8'd11},
    '{8'd7, 8'd64, 8'd20}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic        divClk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  pow2_clkdiv #(.ADDR_W(16), .DATA_W(8), .BASE_ADDR(0), .INST_IDX(1), .STRIDE('h100)) uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .divClk(divClk)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic tick();
    @(posedge clk);
    #(QTR);
  endtask

  task automatic startAndCheck(input int ratio, input string patReq);
    int  lat = 0;
    bit  seen = 0;
    int  bad = 0;
    bit  expv;
    regWrite(EN_A, 8'h80);
    for (int n = 1; n <= 2 + 3 * ratio + 4; n++) begin
      tick();
      if (divClk) begin lat = n; seen = 1; break; end
    end
    check(seen && lat <= 2 + 3 * ratio, "R3", "start latency", lat, 2 + 3 * ratio);
    for (int i = 1; i < 4 * ratio; i++) begin
      tick();
      expv = (ratio == 1) ? 1'b1 : ((i % ratio) < ratio / 2);
      if (divClk !== expv) bad++;
    end
    check(bad == 0, patReq, "waveform mismatches", bad, 0);
    check(regRdData == 8'h81, "R5", "enable reg while running", regRdData, 8'h81);
  endtask

  task automatic stopAndCheck(input int ratio, input int skew);
    int  n = 0;
    bit  gone = 0;
    int  bad = 0;
    repeat (skew) tick();
    regWrite(EN_A, 8'h00);
    for (int k = 1; k <= 3 * ratio + 4; k++) begin
      tick();
      if (regRdData[0] == 1'b0) begin n = k; gone = 1; break; end
    end
    check(gone && n <= 3 * ratio, "R4", "stop latency", n, 3 * ratio);
    check(divClk == 1'b0, "R4", "output at stop", divClk, 0);
    for (int k = 0; k < 2 * ratio + 2; k++) begin
      tick();
      if (divClk !== 1'b0 || regRdData !== 8'h00) bad++;
    end
    check(bad == 0, "R5", "quiet after stop", bad, 0);
  endtask

  initial begin : watchdog
    #(PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] rd;
    int bad;
    bit prev;

    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    bad = 0;
    for (int i = 0; i < 6; i++) begin tick(); if (divClk !== 1'b0) bad++; end
    check(bad == 0, "R1", "output low after reset", bad, 0);
    regRead(FAC_A, rd); check(rd == 8'h00, "R1", "factor after reset", rd, 0);
    regRead(EN_A, rd);  check(rd == 8'h00, "R1", "enable after reset", rd, 0);

    // vector table: R2 ratio decode over every factor
    for (int v = 0; v < 8; v++) begin
      regWrite(FAC_A, VECS[v].factor);
      regRead(FAC_A, rd);
      check(rd == VECS[v].factor, "R6", "factor readback", rd, VECS[v].factor);
      startAndCheck(int'(VECS[v].ratio), "R2");
      stopAndCheck(int'(VECS[v].ratio), int'(VECS[v].skew));
    end

    // R7 unused bits
    regWrite(FAC_A, 8'hFF);
    regRead(FAC_A, rd); check(rd == 8'h07, "R7", "factor unused bits", rd, 8'h07);
    regWrite(EN_A, 8'h7F);
    regRead(EN_A, rd);  check(rd == 8'h00, "R7", "enable unused bits", rd, 0);
    bad = 0;
    for (int i = 0; i < 8; i++) begin tick(); if (divClk !== 1'b0) bad++; end
    check(bad == 0, "R5", "status write has no effect", bad, 0);

    // R6 foreign instance addresses
    regWrite(FAC_A, 8'h03);
    regWrite(FOR_FAC, 8'h05);
    regRead(FAC_A, rd);   check(rd == 8'h03, "R6", "foreign factor write", rd, 3);
    regRead(FOR_FAC, rd); check(rd == 8'h00, "R6", "foreign read", rd, 0);
    regWrite(FOR_EN, 8'h80);
    bad = 0;
    for (int i = 0; i < 10; i++) begin tick(); if (divClk !== 1'b0) bad++; end
    check(bad == 0, "R6", "foreign enable ignored", bad, 0);
    regRead(EN_A, rd); check(rd == 8'h00, "R6", "own enable untouched", rd, 0);

    // R8 factor change while running is deferred
    regWrite(FAC_A, 8'h02);
    startAndCheck(2, "R2");
    regWrite(FAC_A, 8'h04);
    #1 check(regRdData == 8'h04, "R8", "pending factor readback", regRdData, 4);
    tick(); prev = divClk; bad = 0;
    for (int i = 0; i < 8; i++) begin
      tick();
      if (divClk === prev) bad++;
      prev = divClk;
    end
    check(bad == 0, "R8", "old ratio kept while running", bad, 0);
    stopAndCheck(2, 1);
    startAndCheck(8, "R8");
    stopAndCheck(8, 3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule